// File: doc/BRIEF.md
# UART Transmitter with Automatic Clear-to-Send Gating

This block turns bytes into asynchronous serial frames on a single output line. A byte arrives on a valid/ready stream. It is sent as one low start bit, then eight data bits with the least significant bit first, then one high stop bit. Each bit lasts `TICKS_PER_BIT` pulses of an external baud-tick enable, which is 16 by default. The line rests high between frames.

A remote receiver can pause the sender through an active-low clear-to-send input. The input first passes through a synchronizer. When automatic gating is on, the block reads the synchronized level once per frame, at the middle of the stop bit. That single reading decides whether the next byte may follow directly. A frame that has started always runs to the end.

When automatic gating is off, the block ignores the clear-to-send input. It then reports every change of the synchronized level as a one-cycle event pulse, so that a host can take over flow control in software. The block produces no such pulses while automatic gating is on.

Stream rules: a byte is taken in the cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while no frame is in progress, and it does not depend on `tx_valid`. The source must hold `tx_data` steady while `tx_valid` is high and the byte has not yet been taken. Back-pressure lasts for one whole frame, plus any time that flow control holds the sender off.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset `txd` is 1, `cts_change_irq` is 0, and the synchronized clear-to-send level reads as deasserted (1). `txd` stays 1 whenever no frame is in progress.
- R2: A frame is a start bit (0), then data bits 0 to 7 in that order, then a stop bit (1). Every bit lasts exactly 16 baud ticks. `txd` goes low in the clock cycle after the accept and changes on the ticks that close each bit.
- R3: A byte is accepted only when `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the cycle after an accept until the cycle after the stop bit's last tick.
- R4: While `cts_n` stays 0 and data is waiting, the next byte is accepted in the first cycle after the previous stop bit ends. In that case one idle cycle with `txd` at 1 separates the two frames.
- R5: With auto gating on, suppose synchronized `cts_n` is 1 at the sample point, which is the 9th baud tick of the stop bit (tick index 8). The current frame still finishes in full, and no further byte is accepted while `cts_n` remains 1.
- R6: With auto gating on, suppose synchronized `cts_n` is 0 at the sample point and rises later. The byte waiting at the end of that stop bit is still accepted.
- R7: After a hold-off, the next waiting byte is accepted once the synchronized `cts_n` returns to 0.
- R8: With auto gating on and no frame just finished, `tx_ready` is 1 only while synchronized `cts_n` is 0.
- R9: With `auto_cts_en` at 0, bytes are accepted and sent whatever the level of `cts_n`.
- R10: With `auto_cts_en` at 0, each change of the synchronized `cts_n` produces exactly one cycle of `cts_change_irq` at 1. With `auto_cts_en` at 1, `cts_change_irq` stays 0.
- R11: `cts_n` passes through two flip-flops. A change on the pin reaches the gating logic and the event output two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable, 16 per bit |
| auto_cts_en | input | 1 | 1 enables automatic clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | Block takes the byte this cycle if valid |
| txd | output | 1 | Serial output, idles high |
| cts_change_irq | output | 1 | One-cycle pulse on a synchronized clear-to-send change while gating is off |

## Verification
On every cycle the assertions check the following:
- the line is high whenever the block is ready;
- an accept always leads to a low start bit and a busy port;
- the ready signal never rises under auto gating unless the synchronized level or the one-cycle grant allows it;
- the event output stays silent while gating is on.

Some behaviour is visible only over the bench's scenarios and its per-clock reference model:
- the two sides of the mid-stop-bit boundary, that is, late versus early deassertion;
- resumption after a hold-off;
- the exact bit order and bit length of each frame;
- the number of event pulses produced by a train of clear-to-send toggles.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_cts_en,
  output logic cts_s,
  output logic change_irq
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // Reset to the deasserted level so that no event fires out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cts_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign cts_s      = sync_q[STAGES-1];
  assign change_irq = (cts_s ^ last_q) & ~auto_cts_en;
endmodule

// File: rtl/uart_cts_gate.sv
module uart_cts_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_cts_en,
  input  logic cts_s,
  input  logic stop_mid,
  input  logic frame_done,
  output logic grant,
  output logic permit
);
  logic sample_ok_q;

  // sample_ok_q holds the mid-stop decision.
  // grant is valid only in the first idle cycle after a frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_ok_q <= 1'b0;
      grant       <= 1'b0;
    end else begin
      if (stop_mid) sample_ok_q <= ~cts_s;
      grant <= frame_done ? sample_ok_q : 1'b0;
    end
  end

  assign permit = ~auto_cts_en | grant | ~cts_s;
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_cts_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SAMPLE_TICK   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 permit,
  input  logic [DATA_BITS-1:0] data,
  input  logic                 valid,
  output logic                 ready,
  output logic                 txd,
  output logic                 stop_mid,
  output logic                 frame_done
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] MID_TICK  = CW'(SAMPLE_TICK);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);

  tx_state_e            state_q;
  logic [CW-1:0]        tick_q;
  logic [BW-1:0]        bit_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 txd_q;
  logic                 bit_end;

  assign ready      = (state_q == TX_IDLE) && permit;
  assign bit_end    = baud_tick && (tick_q == LAST_TICK);
  assign stop_mid   = (state_q == TX_STOP) && baud_tick && (tick_q == MID_TICK);
  assign frame_done = (state_q == TX_STOP) && bit_end;
  assign txd        = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      txd_q   <= 1'b1;
    end else if (state_q == TX_IDLE) begin
      if (valid && ready) begin
        shift_q <= data;
        tick_q  <= '0;
        txd_q   <= 1'b0;
        state_q <= TX_START;
      end
    end else if (baud_tick) begin
      if (tick_q != LAST_TICK) begin
        tick_q <= tick_q + 1'b1;
      end else begin
        tick_q <= '0;
        unique case (state_q)
          TX_START: begin
            txd_q   <= shift_q[0];
            shift_q <= shift_q >> 1;
            bit_q   <= '0;
            state_q <= TX_DATA;
          end
          TX_DATA: begin
            if (bit_q == LAST_BIT) begin
              txd_q   <= 1'b1;
              state_q <= TX_STOP;
            end else begin
              txd_q   <= shift_q[0];
              shift_q <= shift_q >> 1;
              bit_q   <= bit_q + 1'b1;
            end
          end
          default: begin
            txd_q   <= 1'b1;
            state_q <= TX_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SAMPLE_TICK   = TICKS_PER_BIT / 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 auto_cts_en,
  input  logic                 cts_n,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic                 txd,
  output logic                 cts_change_irq
);
  logic cts_s;
  logic grant;
  logic permit;
  logic stop_mid;
  logic frame_done;

  uart_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_n       (cts_n),
    .auto_cts_en (auto_cts_en),
    .cts_s       (cts_s),
    .change_irq  (cts_change_irq)
  );

  uart_cts_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_cts_en (auto_cts_en),
    .cts_s       (cts_s),
    .stop_mid    (stop_mid),
    .frame_done  (frame_done),
    .grant       (grant),
    .permit      (permit)
  );

  uart_tx_shifter #(
    .DATA_BITS     (DATA_BITS),
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .SAMPLE_TICK   (SAMPLE_TICK)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .permit     (permit),
    .data       (tx_data),
    .valid      (tx_valid),
    .ready      (tx_ready),
    .txd        (txd),
    .stop_mid   (stop_mid),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_cts_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic cts_change_irq,
  input logic cts_s,
  input logic grant
);
  // R1: the block is ready only while the line idles high.
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  // R2: an accept is followed by the start bit.
  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !txd);

  // R3: no second accept right after one.
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R8: under auto gating, ready needs the synchronized level or the grant.
  a_r8_gate_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && tx_ready) |-> (!cts_s || grant));

  // R10: events are silent while auto gating is on.
  a_r10_no_event_when_auto: assert property (@(posedge clk) disable iff (!rst_n)
    auto_cts_en |-> !cts_change_irq);
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .auto_cts_en    (auto_cts_en),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .txd            (txd),
  .cts_change_irq (cts_change_irq),
  .cts_s          (cts_s),
  .grant          (grant)
);

// File: tb/uart_cts_tx_test.sv
`timescale 1ns/1ps
module uart_cts_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       auto_cts_en = 1'b0;
  logic       cts_n = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       txd;
  logic       cts_change_irq;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  int irq_seen = 0;
  logic [7:0] queue_q[$];

  // Reference model state.
  logic m_s1 = 1'b1, m_s2 = 1'b1, m_prev = 1'b1;
  logic m_busy = 1'b0, m_grant = 1'b0, m_samp = 1'b0, m_txd = 1'b1, m_acc = 1'b0;
  int   m_pos = 0;
  int   m_starts = 0;
  logic [7:0] m_byte = 8'h00;

  always #2 clk = ~clk;

  uart_cts_tx uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .baud_tick      (baud_tick),
    .auto_cts_en    (auto_cts_en),
    .cts_n          (cts_n),
    .tx_data        (tx_data),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .txd            (txd),
    .cts_change_irq (cts_change_irq)
  );

  function automatic logic frame_bit(int pos, logic [7:0] b);
    int idx = pos / 16;
    if (idx == 0) return 1'b0;
    if (idx <= 8) return b[idx-1];
    return 1'b1;
  endfunction

  function automatic logic exp_ready();
    return !m_busy && (!auto_cts_en || m_grant || !m_s2);
  endfunction

  // Baud tick: one pulse every 4 clocks.
  int div = 0;
  always @(posedge clk) begin
    #1;
    div = (div + 1) % 4;
    baud_tick = (div == 0);
  end

  // Behavioural reference model, advanced on every clock.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1;
      m_busy = 1'b0; m_grant = 1'b0; m_samp = 1'b0; m_txd = 1'b1; m_acc = 1'b0;
      m_pos = 0;
    end else begin
      m_acc = tx_valid && exp_ready();
      if (!m_busy) begin
        m_grant = 1'b0;
        if (m_acc) begin
          m_busy = 1'b1; m_pos = 0; m_byte = tx_data; m_txd = 1'b0; m_starts++;
        end
      end else if (baud_tick) begin
        if (m_pos == 152) m_samp = !m_s2;
        m_pos++;
        if (m_pos == 160) begin
          m_busy = 1'b0; m_grant = m_samp; m_txd = 1'b1;
        end else begin
          m_txd = frame_bit(m_pos, m_byte);
        end
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = cts_n;
    end
  end

  // Stream source: pops the head once the model has seen it taken.
  always @(posedge clk) begin
    #1;
    if (m_acc && queue_q.size() > 0) void'(queue_q.pop_front());
    tx_valid = (queue_q.size() > 0);
    tx_data  = (queue_q.size() > 0) ? queue_q[0] : 8'h00;
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (txd !== m_txd) begin
        errors++;
        $display("FAIL R2 txd: actual %b expected %b at cycle %0d", txd, m_txd, cycles);
      end
      if (tx_ready !== exp_ready()) begin
        errors++;
        $display("FAIL R3/R8 tx_ready: actual %b expected %b at cycle %0d", tx_ready, exp_ready(), cycles);
      end
      if (cts_change_irq !== ((m_s2 ^ m_prev) && !auto_cts_en)) begin
        errors++;
        $display("FAIL R10 cts_change_irq: actual %b expected %b at cycle %0d",
                 cts_change_irq, (m_s2 ^ m_prev) && !auto_cts_en, cycles);
      end
      if (cts_change_irq === 1'b1) irq_seen++;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    vectors++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic wait_pos(input int p);
    while (!(m_busy && m_pos == p)) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    while (m_busy || queue_q.size() > 0 && exp_ready()) @(posedge clk);
    wait_clk(4);
  endtask

  // Watchdog.
  initial begin
    wait_clk(150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected 0 remaining cycles", 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int s0;
    wait_clk(5);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state.
    check("R1 txd after reset", txd, 1);
    check("R1 irq after reset", cts_change_irq, 0);

    // R9, R2, R4: gating off, cts deasserted, two bytes back to back.
    s0 = m_starts;
    queue_q.push_back(8'hA5); queue_q.push_back(8'h3C);
    wait_clk(10);
    wait_idle();
    check("R9 bytes sent with gating off", m_starts - s0, 2);

    // R8, R7: gating on, cts deasserted, byte held until cts asserts.
    @(posedge clk); #1 auto_cts_en = 1'b1;
    s0 = m_starts;
    queue_q.push_back(8'h5A);
    wait_clk(300);
    check("R8 held while cts deasserted", m_starts - s0, 0);
    check("R8 line idle while held", txd, 1);
    #1 cts_n = 1'b0;
    wait_clk(10);
    check("R7 R11 start after cts asserts", m_starts - s0, 1);
    wait_idle();

    // R5, R7: deassert well before the mid-stop sample.
    s0 = m_starts;
    queue_q.push_back(8'h81); queue_q.push_back(8'h7E); queue_q.push_back(8'hC3);
    wait_pos(140);
    cts_n = 1'b1;
    wait_idle();
    wait_clk(400);
    check("R5 next byte withheld", m_starts - s0, 1);
    check("R5 pending bytes kept", queue_q.size(), 2);
    @(posedge clk); #1 cts_n = 1'b0;
    wait_clk(10);
    wait_idle();
    check("R7 resumed and drained", m_starts - s0, 3);

    // R6: deassert after the mid-stop sample; next byte still starts.
    s0 = m_starts;
    queue_q.push_back(8'h0F); queue_q.push_back(8'hF0); queue_q.push_back(8'h55);
    wait_pos(156);
    cts_n = 1'b1;
    wait_clk(200);
    check("R6 late deassert lets next byte go", m_starts - s0, 2);
    wait_idle();
    wait_clk(300);
    check("R5 third byte withheld", m_starts - s0, 2);
    @(posedge clk); #1 cts_n = 1'b0;
    wait_clk(10);
    wait_idle();
    check("R7 third byte sent", m_starts - s0, 3);

    // R10: events with gating off, none with gating on.
    @(posedge clk); #1 auto_cts_en = 1'b0;
    wait_clk(5);
    irq_seen = 0;
    for (int k = 0; k < 4; k++) begin
      #1 cts_n = ~cts_n;
      wait_clk(6);
    end
    check("R10 one pulse per change", irq_seen, 4);
    @(posedge clk); #1 auto_cts_en = 1'b1;
    irq_seen = 0;
    for (int k = 0; k < 4; k++) begin
      #1 cts_n = ~cts_n;
      wait_clk(6);
    end
    check("R10 silent with gating on", irq_seen, 0);

    // R9: gating off sends even with cts deasserted.
    @(posedge clk); #1 auto_cts_en = 1'b0; cts_n = 1'b1;
    s0 = m_starts;
    queue_q.push_back(8'h99);
    wait_clk(10);
    wait_idle();
    check("R9 sent regardless of cts", m_starts - s0, 1);
    check("R1 line idle after frame", txd, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule